// File: doc/BRIEF.md
# DDR3 Open-Row Command Scheduler

This block sits between a burst request source and a DFI-style DRAM command port. It turns each request (direction, bank, row, column) into the shortest DDR3 command sequence the current bank state allows. A request to a row that is already open needs only a column command. A request to a closed bank needs an activate first. A request to a bank holding a different row needs a precharge, then an activate. Each of the eight banks keeps its own open row, so streams that stay inside open rows run at the column-to-column rate with no activates.

After reset the scheduler runs the DRAM start-up sequence. It waits a power-up interval and then loads the four mode registers. The values chosen switch the DRAM's delay-locked loop off, so the device can run at a low clock rate (125 MHz or less). A refresh timer interrupts traffic at a fixed interval. On each refresh the scheduler closes every bank, issues a refresh and holds off new activates for the refresh recovery time.

Requests are served strictly in arrival order, with no re-ordering or merging. A request is accepted (valid and ready high at a clock edge) in the cycle its column command is decided, and that command appears on the DFI pins one cycle later. Data movement is left to the PHY side.

Top module: `ddr_open_row_sched`

## Requirements
- R1: After reset release the scheduler waits at least T_INIT cycles and then issues four MODE-REGISTER-SET commands, spaced at least T_MRD apart, in the order MR2, MR3, MR1, MR0. The bank pins carry the register number, and the MR1 write has address bit 0 set, which disables the DLL. No other command is issued and `init_done` stays low until all four are done.
- R2: DFI command pins {cs_n, ras_n, cas_n, we_n} use these encodings: idle 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE-REGISTER-SET 0000. During reset the pins hold idle, and `req_ready` and `init_done` are low.
- R3: A request to the open row of its bank is served with a READ or WRITE and no ACTIVATE. Two same-direction column commands with no command between them are exactly T_CCD cycles apart.
- R4: A request to a bank with no open row gets ACTIVATE (bank, row on address), then its column command at least T_RCD cycles later.
- R5: A request to a bank holding a different row gets PRECHARGE of that bank (address bit 10 low), then ACTIVATE at least T_RP cycles later. No PRECHARGE is issued for a row hit.
- R6: Column commands follow the order in which requests were accepted. Each carries the request's bank, direction and column (address bits [COL_W-1:0], bit 10 low). `req_ready` is high only after initialisation, and is followed one cycle later by a READ or WRITE.
- R7: A READ following a WRITE comes at least T_WTR cycles after it. A WRITE following a READ comes at least T_RTW cycles after it.
- R8: Every T_REFI cycles a refresh is due. If any bank is open, the scheduler issues PRECHARGE with address bit 10 high (all banks). It then issues REFRESH at least T_RP later, with every bank closed. No ACTIVATE follows within T_RFC cycles, and the next request to any bank needs an ACTIVATE.
- R9: All eight banks can hold an open row at once. After one row is opened in each bank, requests to those rows issue no ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and DRAM command clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Request accepted at this edge; its column command follows |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column of the BL8 burst |
| init_done | output | 1 | Mode-register set-up finished |
| dfi_cs_n | output | 1 | Chip select, active low |
| dfi_ras_n | output | 1 | Row strobe, active low |
| dfi_cas_n | output | 1 | Column strobe, active low |
| dfi_we_n | output | 1 | Write enable, active low |
| dfi_bank | output | BANK_W | Bank address |
| dfi_address | output | ROW_W | Row, column or mode value; bit 10 selects all banks on precharge |

## Verification
The bound checker watches the command pins on every cycle. It checks that only mode-register commands come before `init_done`, that column commands respect T_CCD, that activates keep T_RP after a precharge and T_RFC after a refresh, that refresh finds every bank closed, and that each accepted request produces a column command on the next cycle. The bench's reference model covers what a per-cycle property cannot. It checks the start-up order and the DLL-off value, request order and field matching, whether a hit, a closed bank or a row miss produced the right activate or precharge, read/write turnaround, and eight banks staying open together.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ST_POWER,
    ST_MODE,
    ST_RUN
  } sched_state_e;

  // Mode-register load order: MR2, MR3, MR1, MR0
  function automatic logic [1:0] mode_reg_sel(input logic [1:0] step);
    case (step)
      2'd0:    mode_reg_sel = 2'd2;
      2'd1:    mode_reg_sel = 2'd3;
      2'd2:    mode_reg_sel = 2'd1;
      default: mode_reg_sel = 2'd0;
    endcase
  endfunction

  // MR1 bit 0 disables the DLL; MR0 selects BL8 and CAS latency 6
  function automatic logic [15:0] mode_reg_val(input logic [1:0] step);
    case (step)
      2'd2:    mode_reg_val = 16'h0001;
      2'd3:    mode_reg_val = 16'h0020;
      default: mode_reg_val = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/ddr_open_rows.sv
module ddr_open_rows #(
  parameter int BANKS = 8,
  parameter int ROW_W = 14,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_hit,
  output logic              any_open,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              close_en,
  input  logic [BANK_W-1:0] close_bank,
  input  logic              close_all
);

  logic [BANKS-1:0] open_vec;
  logic [ROW_W-1:0] row_tab [BANKS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (rst) begin
        open_vec[b] <= 1'b0;
        row_tab[b]  <= '0;
      end else if (close_all || (close_en && close_bank == BANK_W'(b))) begin
        open_vec[b] <= 1'b0;
      end else if (set_en && set_bank == BANK_W'(b)) begin
        open_vec[b] <= 1'b1;
        row_tab[b]  <= set_row;
      end
    end
  end

  assign look_open = open_vec[look_bank];
  assign look_hit  = open_vec[look_bank] && (row_tab[look_bank] == look_row);
  assign any_open  = |open_vec;

endmodule

// File: rtl/ddr_refresh_tick.sv
module ddr_refresh_tick #(
  parameter int T_REFI = 975,
  localparam int CNT_W = $clog2(T_REFI + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ack,
  output logic pending
);

  logic [CNT_W-1:0] cnt;
  logic             fire;

  assign fire = enable && (cnt == CNT_W'(T_REFI - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt     <= fire ? '0 : cnt + 1'b1;
      pending <= (pending && !ack) || fire;
    end
  end

endmodule

// File: rtl/ddr_open_row_sched.sv
module ddr_open_row_sched
  import ddr_sched_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int T_INIT = 500,
  parameter int T_MRD  = 4,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_CCD  = 4,
  parameter int T_WTR  = 8,
  parameter int T_RTW  = 6,
  parameter int T_RFC  = 14,
  parameter int T_REFI = 975,
  localparam int BANK_W = $clog2(BANKS),
  localparam int GAP_W  = $clog2(T_INIT + T_MRD + T_RP + T_RCD + T_CCD
                                 + T_WTR + T_RTW + T_RFC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              init_done,
  output logic              dfi_cs_n,
  output logic              dfi_ras_n,
  output logic              dfi_cas_n,
  output logic              dfi_we_n,
  output logic [BANK_W-1:0] dfi_bank,
  output logic [ROW_W-1:0]  dfi_address
);

  sched_state_e      st, st_n;
  logic [GAP_W-1:0]  gap, gap_n;
  logic [1:0]        mode_step, mode_step_n;
  logic              last_wr, last_wr_n;
  logic              col_seen, col_seen_n;
  logic              turn_done, turn_done_n;
  dram_cmd_e         cmd_q, cmd_n;
  logic [BANK_W-1:0] bank_n;
  logic [ROW_W-1:0]  addr_n;

  logic look_open, look_hit, any_open;
  logic set_en, close_en, close_all;
  logic ref_pending, ref_ack;

  ddr_open_rows #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst),
    .look_bank(req_bank), .look_row(req_row),
    .look_open(look_open), .look_hit(look_hit), .any_open(any_open),
    .set_en(set_en), .set_bank(req_bank), .set_row(req_row),
    .close_en(close_en), .close_bank(req_bank), .close_all(close_all)
  );

  ddr_refresh_tick #(.T_REFI(T_REFI)) u_ref (
    .clk(clk), .rst(rst), .enable(st == ST_RUN),
    .ack(ref_ack), .pending(ref_pending)
  );

  always_comb begin
    st_n        = st;
    gap_n       = gap;
    mode_step_n = mode_step;
    last_wr_n   = last_wr;
    col_seen_n  = col_seen;
    turn_done_n = turn_done;
    cmd_n       = CMD_NOP;
    bank_n      = '0;
    addr_n      = '0;
    set_en      = 1'b0;
    close_en    = 1'b0;
    close_all   = 1'b0;
    ref_ack     = 1'b0;
    req_ready   = 1'b0;
    if (gap != '0) begin
      gap_n = gap - 1'b1;
    end else begin
      case (st)
        ST_POWER: st_n = ST_MODE;
        ST_MODE: begin
          cmd_n       = CMD_MRS;
          bank_n      = BANK_W'(mode_reg_sel(mode_step));
          addr_n      = ROW_W'(mode_reg_val(mode_step));
          gap_n       = GAP_W'(T_MRD - 1);
          mode_step_n = mode_step + 1'b1;
          if (mode_step == 2'd3) st_n = ST_RUN;
        end
        default: begin
          if (ref_pending) begin
            if (any_open) begin
              cmd_n      = CMD_PRE;
              addr_n[10] = 1'b1;
              close_all  = 1'b1;
              gap_n      = GAP_W'(T_RP - 1);
            end else begin
              cmd_n   = CMD_REF;
              ref_ack = 1'b1;
              gap_n   = GAP_W'(T_RFC - 1);
            end
          end else if (req_valid) begin
            bank_n = req_bank;
            if (!look_open) begin
              cmd_n  = CMD_ACT;
              addr_n = req_row;
              set_en = 1'b1;
              gap_n  = GAP_W'(T_RCD - 1);
            end else if (!look_hit) begin
              cmd_n    = CMD_PRE;
              close_en = 1'b1;
              gap_n    = GAP_W'(T_RP - 1);
            end else if (col_seen && (last_wr != req_write) && !turn_done) begin
              // stall for the bus turnaround beyond the column spacing
              gap_n       = req_write ? GAP_W'(T_RTW - T_CCD - 1)
                                      : GAP_W'(T_WTR - T_CCD - 1);
              turn_done_n = 1'b1;
            end else begin
              cmd_n       = req_write ? CMD_WR : CMD_RD;
              addr_n      = ROW_W'(req_col);
              req_ready   = 1'b1;
              gap_n       = GAP_W'(T_CCD - 1);
              last_wr_n   = req_write;
              col_seen_n  = 1'b1;
              turn_done_n = 1'b0;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_POWER;
      gap         <= GAP_W'(T_INIT - 1);
      mode_step   <= '0;
      last_wr     <= 1'b0;
      col_seen    <= 1'b0;
      turn_done   <= 1'b0;
      cmd_q       <= CMD_NOP;
      dfi_bank    <= '0;
      dfi_address <= '0;
    end else begin
      st          <= st_n;
      gap         <= gap_n;
      mode_step   <= mode_step_n;
      last_wr     <= last_wr_n;
      col_seen    <= col_seen_n;
      turn_done   <= turn_done_n;
      cmd_q       <= cmd_n;
      dfi_bank    <= bank_n;
      dfi_address <= addr_n;
    end
  end

  assign {dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n} = cmd_q;
  assign init_done = (st == ST_RUN);

endmodule

// File: rtl/ddr_sched_checks.sv
module ddr_sched_checks #(
  parameter int T_RP  = 2,
  parameter int T_CCD = 4,
  parameter int T_RFC = 14
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd,
  input logic       init_done,
  input logic       req_ready,
  input logic       any_open
);

  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_NOP = 4'b0111;

  logic [15:0] since_pre, since_ref, since_col;
  logic        is_col;

  assign is_col = (cmd == C_RD) || (cmd == C_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pre <= '1;
      since_ref <= '1;
      since_col <= '1;
    end else begin
      since_pre <= (cmd == C_PRE) ? 16'd1 : (since_pre == '1 ? since_pre : since_pre + 1'b1);
      since_ref <= (cmd == C_REF) ? 16'd1 : (since_ref == '1 ? since_ref : since_ref + 1'b1);
      since_col <= is_col         ? 16'd1 : (since_col == '1 ? since_col : since_col + 1'b1);
    end
  end

  p_init_only_mrs_r1: assert property (@(posedge clk) disable iff (rst)
    (!init_done && cmd != C_NOP) |-> cmd == C_MRS);

  p_ready_after_init_r6: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> init_done);

  p_ready_gives_col_r6: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> (cmd == C_RD || cmd == C_WR));

  p_col_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    is_col |-> since_col >= 16'(T_CCD));

  p_act_after_pre_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |-> since_pre >= 16'(T_RP));

  p_act_after_ref_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |-> since_ref >= 16'(T_RFC));

  p_ref_all_closed_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF) |-> !any_open);

endmodule

bind ddr_open_row_sched ddr_sched_checks #(
  .T_RP(T_RP), .T_CCD(T_CCD), .T_RFC(T_RFC)
) u_checks (
  .clk(clk), .rst(rst),
  .cmd({dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n}),
  .init_done(init_done), .req_ready(req_ready), .any_open(any_open)
);

// File: tb/ddr_open_row_sched_test.sv
module ddr_open_row_sched_test;

  localparam int BANKS = 8, ROW_W = 14, COL_W = 10, BANK_W = 3;
  localparam int T_INIT = 20, T_MRD = 4, T_RP = 3, T_RCD = 3, T_CCD = 4;
  localparam int T_WTR = 7, T_RTW = 6, T_RFC = 10, T_REFI = 400;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ready, init_done, cs_n, ras_n, cas_n, we_n;
  logic [BANK_W-1:0] dfi_bank;
  logic [ROW_W-1:0]  dfi_address;

  ddr_open_row_sched #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .T_INIT(T_INIT), .T_MRD(T_MRD),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CCD(T_CCD), .T_WTR(T_WTR), .T_RTW(T_RTW),
    .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .init_done(init_done), .dfi_cs_n(cs_n), .dfi_ras_n(ras_n), .dfi_cas_n(cas_n),
    .dfi_we_n(we_n), .dfi_bank(dfi_bank), .dfi_address(dfi_address)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rst_cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // accepted-request queue
  bit   q_w [0:1023];
  int   q_b [0:1023];
  int   q_r [0:1023];
  int   q_c [0:1023];
  int   wr_ptr = 0, rd_ptr = 0;

  // reference bank model
  bit   m_open [0:7];
  int   m_row  [0:7];
  int   last_act [0:7];
  int   last_pre [0:7];
  int   last_prea = -1000, last_ref = -1000, last_mrs = -1000;
  int   last_col = -1000;
  bit   last_col_w = 0, col_seen = 0;
  int   prev_cmd = 7;
  int   mrs_cnt = 0, act_cnt = 0, pre_cnt = 0, ref_cnt = 0, tight_cnt = 0;

  function automatic int exp_mr(input int step);
    case (step)
      0: return 2;
      1: return 3;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_any_open();
    for (int b = 0; b < 8; b++) if (m_open[b]) return 1;
    return 0;
  endfunction

  initial begin
    for (int b = 0; b < 8; b++) begin
      m_open[b] = 0; m_row[b] = 0; last_act[b] = -1000; last_pre[b] = -1000;
    end
  end

  always @(posedge clk) begin
    cyc++;
    #1;
    if (!rst) begin
      int c, b;
      c = {cs_n, ras_n, cas_n, we_n};
      b = int'(dfi_bank);
      if (c != 4'b0111 && c != 4'b0000)
        chk(mrs_cnt == 4, "R1 command before mode setup finished", mrs_cnt, 4);
      case (c)
        4'b0000: begin
          chk(mrs_cnt < 4, "R1 extra mode-register command", mrs_cnt, 3);
          chk(b == exp_mr(mrs_cnt), "R1 mode-register order", b, exp_mr(mrs_cnt));
          if (mrs_cnt == 0)
            chk(cyc - rst_cyc >= T_INIT, "R1 power-up wait", cyc - rst_cyc, T_INIT);
          else
            chk(cyc - last_mrs >= T_MRD, "R1 mode-register spacing", cyc - last_mrs, T_MRD);
          if (b == 1) chk(dfi_address[0] == 1'b1, "R1 DLL-off bit in MR1", int'(dfi_address[0]), 1);
          last_mrs = cyc;
          mrs_cnt++;
        end
        4'b0011: begin
          chk(!m_open[b], "R4 activate to an open bank", int'(m_open[b]), 0);
          chk(int'(dfi_address) == int'(req_row), "R4 activate row", int'(dfi_address), int'(req_row));
          chk(cyc - last_pre[b] >= T_RP && cyc - last_prea >= T_RP, "R5 activate after precharge",
              cyc - last_pre[b], T_RP);
          chk(cyc - last_ref >= T_RFC, "R8 activate after refresh", cyc - last_ref, T_RFC);
          m_open[b] = 1; m_row[b] = int'(dfi_address); last_act[b] = cyc; act_cnt++;
        end
        4'b0010: begin
          if (dfi_address[10]) begin
            chk(model_any_open(), "R8 precharge-all with no open bank", 0, 1);
            for (int k = 0; k < 8; k++) m_open[k] = 0;
            last_prea = cyc;
          end else begin
            chk(m_open[b] && m_row[b] != int'(req_row), "R5 precharge without row miss",
                m_row[b], int'(req_row));
            m_open[b] = 0; last_pre[b] = cyc; pre_cnt++;
          end
        end
        4'b0001: begin
          chk(!model_any_open(), "R8 refresh with open bank", 1, 0);
          chk(cyc - last_prea >= T_RP || last_prea < 0, "R8 refresh after precharge-all",
              cyc - last_prea, T_RP);
          last_ref = cyc; ref_cnt++;
        end
        4'b0100, 4'b0101: begin
          bit w;
          w = (c == 4'b0100);
          chk(rd_ptr < wr_ptr, "R6 column command without request", rd_ptr, wr_ptr);
          chk(w == q_w[rd_ptr], "R6 direction", int'(w), int'(q_w[rd_ptr]));
          chk(b == q_b[rd_ptr], "R6 bank", b, q_b[rd_ptr]);
          chk(int'(dfi_address[COL_W-1:0]) == q_c[rd_ptr] && !dfi_address[10], "R6 column",
              int'(dfi_address), q_c[rd_ptr]);
          chk(m_open[b] && m_row[b] == q_r[rd_ptr], "R3 column to open row", m_row[b], q_r[rd_ptr]);
          chk(cyc - last_act[b] >= T_RCD, "R4 activate-to-column", cyc - last_act[b], T_RCD);
          if (col_seen) begin
            if (w != last_col_w) begin
              if (w) chk(cyc - last_col >= T_RTW, "R7 read-to-write turnaround", cyc - last_col, T_RTW);
              else   chk(cyc - last_col >= T_WTR, "R7 write-to-read turnaround", cyc - last_col, T_WTR);
            end else begin
              chk(cyc - last_col >= T_CCD, "R3 column spacing", cyc - last_col, T_CCD);
              if (prev_cmd == c) begin
                chk(cyc - last_col == T_CCD, "R3 back-to-back hit spacing", cyc - last_col, T_CCD);
                tight_cnt++;
              end
            end
          end
          rd_ptr++;
          last_col = cyc; last_col_w = w; col_seen = 1;
        end
        default: ;
      endcase
      if (c != 4'b0111) prev_cmd = c;
    end
  end

  task automatic send(input bit w, input int b, input int r, input int c);
    @(negedge clk);
    req_valid = 1; req_write = w;
    req_bank = BANK_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
    while (!req_ready) @(negedge clk);
    q_w[wr_ptr] = w; q_b[wr_ptr] = b; q_r[wr_ptr] = r; q_c[wr_ptr] = c;
    wr_ptr++;
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 0;
    while (rd_ptr != wr_ptr) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int acts0, refs0, pres0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2 idle during reset",
        int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(!req_ready && !init_done, "R2 ready and init low in reset",
        int'({req_ready, init_done}), 0);
    rst = 0;
    rst_cyc = cyc;
    req_valid = 1; req_write = 0; req_bank = '0; req_row = ROW_W'(5);
    while (!init_done) @(negedge clk);
    chk(wr_ptr == 0 && rd_ptr == 0, "R1 no request served during setup", rd_ptr, 0);
    chk(mrs_cnt == 4, "R1 four mode-register commands", mrs_cnt, 4);
    req_valid = 0;

    // R4 and R9: open one row in every bank, then hit all of them
    for (int b = 0; b < 8; b++) send(0, b, 5, 0);
    acts0 = act_cnt; refs0 = ref_cnt;
    for (int b = 0; b < 8; b++) send(0, b, 5, 8);
    for (int b = 0; b < 8; b++) send(0, b, 5, 16);
    drain();
    if (ref_cnt == refs0) chk(act_cnt == acts0, "R9 eight open rows need no activate", act_cnt - acts0, 0);

    // R5 row miss, then R7 turnaround in both directions
    pres0 = pre_cnt;
    send(1, 0, 9, 24);
    send(0, 0, 9, 32);
    send(1, 0, 9, 40);
    send(1, 0, 9, 48);
    drain();
    if (ref_cnt == refs0) chk(pre_cnt == pres0 + 1, "R5 one precharge for the miss", pre_cnt - pres0, 1);

    // random traffic over a few rows per bank
    for (int i = 0; i < 300; i++)
      send(1'($urandom % 2), int'($urandom % 8), int'($urandom % 3), int'(($urandom % 128) * 8));
    drain();

    while (ref_cnt < 2) @(negedge clk);
    // after a refresh every bank is closed, so a new request must activate
    acts0 = act_cnt;
    send(0, 3, 1, 0);
    drain();
    chk(act_cnt == acts0 + 1, "R8 activate needed after refresh", act_cnt - acts0, 1);
    chk(ref_cnt >= 2, "R8 periodic refresh", ref_cnt, 2);
    chk(tight_cnt > 0, "R3 back-to-back hits seen", tight_cnt, 1);
    chk(rd_ptr == wr_ptr, "R6 every request served", rd_ptr, wr_ptr);
    finish_run();
  end

endmodule